// File: doc/BRIEF.md
# Automatic Transmit/Receive GPIO Controller

This block drives two banks of general-purpose pins that sit beside a radio front end: a receive-side bank and a transmit-side bank. Each output pin can be driven by a value that software wrote, by a pattern tied to the radio's present activity, or by one of two internal debug buses. Software configures the block through a single register-write port and reads it back through a combinational read port.

The radio's activity arrives as two live flags, `tx_active` and `rx_active`. Together they pick one of four states: idle, transmitting only, receiving only, or full duplex. A table holds one pattern per state for each bank. Pins that software hands to the automatic source then follow the radio without any further register traffic. Direction bits decide which pins are outputs. An input pin is never driven, and reading a bank's io register returns what the pads currently show.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: After reset, every pin of both banks is an input (`*_pad_oe` = 0), every `*_pad_out` is 0, and every writable register reads back 0.
- R2: The register address is 4 bits. When bit 3 is 0, the access goes to a bank register: bit 2 selects the bank (0 = receive, 1 = transmit), and bits 1:0 select the register (0 = io, 1 = direction, 2 = select, 3 = debug enable). When bit 3 is 1, the access goes to a pattern register: bits 2:1 hold the state index and bit 0 selects the bank. A write takes effect at the clock edge on which `wr_en` is sampled high.
- R3: A direction bit of 1 makes the pin an output. Each `*_pad_oe` bit equals its direction bit from the cycle after the write onward.
- R4: For an output pin whose debug bit is 0 and whose select bit is 0, the pin drives the io register bit that software wrote.
- R5: For an output pin whose debug bit is 0 and whose select bit is 1, the pin drives the bit of the current state's pattern. The state index is {tx_active, rx_active}: 00 is idle, 01 is receive only, 10 is transmit only, and 11 is full duplex.
- R6: When the activity flags change, the pattern driven on the pins changes in the same cycle, with no clock edge needed.
- R7: For an output pin whose debug bit is 1, the select bit chooses the source: select 0 drives debug bus 0 and select 1 drives debug bus 1.
- R8: A pin whose direction bit is 0 drives 0 on `*_pad_out`, whatever source it selects.
- R9: Reading a bank's io address returns that bank's pad inputs. Reading any other address returns the last value written to it.
- R10: A write to one bank's registers or patterns leaves the other bank's outputs and enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (map in R2) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address (same map) |
| rd_data | output | 16 | Read data, combinational |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| rx_pad_in | input | 16 | Receive-bank pad input values |
| tx_pad_in | input | 16 | Transmit-bank pad input values |
| rx_dbg0 | input | 16 | Receive-bank debug bus 0 |
| rx_dbg1 | input | 16 | Receive-bank debug bus 1 |
| tx_dbg0 | input | 16 | Transmit-bank debug bus 0 |
| tx_dbg1 | input | 16 | Transmit-bank debug bus 1 |
| rx_pad_out | output | 16 | Receive-bank pin output values |
| rx_pad_oe | output | 16 | Receive-bank output enables |
| tx_pad_out | output | 16 | Transmit-bank pin output values |
| tx_pad_oe | output | 16 | Transmit-bank output enables |

## Verification
The bench sets each of the four flag combinations and gives every state a distinct pattern. A design that swapped the two flags in the state index would show the receive-only pattern while the radio transmits. Select masks are mixed within one bank, so a mux that routed a whole bank instead of single pins would corrupt half of the bits. The bench also enables debug on only half of the pins, so a design that ignored the select bit in debug mode would show the wrong bus. It clears direction bits while sources stay active, so a design that leaked values onto input pins would show them on the outputs. Finally, it checks the receive bank after each transmit-bank write to catch address decoding that lets one bank's writes land in the other.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;
   localparam int ADDR_W  = 4;
   localparam int N_STATE = 4;
   localparam int N_BANK  = 2;

   typedef enum logic [1:0] {
      REG_IO  = 2'd0,
      REG_DIR = 2'd1,
      REG_SEL = 2'd2,
      REG_DBG = 2'd3
   } bank_reg_e;
endpackage

// File: rtl/atr_gpio_bank_regs.sv
module atr_gpio_bank_regs
   import atr_gpio_pkg::*;
#(
   parameter int PIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  bank_reg_e        wr_reg,
   input  logic [PIN_W-1:0] wr_data,
   output logic [PIN_W-1:0] io_q,
   output logic [PIN_W-1:0] dir_q,
   output logic [PIN_W-1:0] sel_q,
   output logic [PIN_W-1:0] dbg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_q  <= '0;
         dir_q <= '0;
         sel_q <= '0;
         dbg_q <= '0;
      end else if (wr_en) begin
         case (wr_reg)
            REG_IO:  io_q  <= wr_data;
            REG_DIR: dir_q <= wr_data;
            REG_SEL: sel_q <= wr_data;
            REG_DBG: dbg_q <= wr_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/atr_gpio_pattern_tbl.sv
module atr_gpio_pattern_tbl
   import atr_gpio_pkg::*;
#(
   parameter int PIN_W = 16,
   localparam int IDX_W = $clog2(N_STATE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PIN_W-1:0] wr_data,
   input  logic [IDX_W-1:0] live_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PIN_W-1:0] pat_live,
   output logic [PIN_W-1:0] pat_rd
);
   logic [PIN_W-1:0] pat_q [N_STATE];

   for (genvar s = 0; s < N_STATE; s++) begin : g_state
      always_ff @(posedge clk) begin
         if (!rst_n)
            pat_q[s] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(s)))
            pat_q[s] <= wr_data;
      end
   end

   assign pat_live = pat_q[live_idx];
   assign pat_rd   = pat_q[rd_idx];
endmodule

// File: rtl/atr_gpio_pinmux.sv
module atr_gpio_pinmux #(
   parameter int PIN_W = 16
) (
   input  logic [PIN_W-1:0] io_q,
   input  logic [PIN_W-1:0] dir_q,
   input  logic [PIN_W-1:0] sel_q,
   input  logic [PIN_W-1:0] dbg_q,
   input  logic [PIN_W-1:0] pat,
   input  logic [PIN_W-1:0] dbg0,
   input  logic [PIN_W-1:0] dbg1,
   output logic [PIN_W-1:0] pad_out,
   output logic [PIN_W-1:0] pad_oe
);
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      logic src;
      always_comb begin
         unique case ({dbg_q[i], sel_q[i]})
            2'b00:   src = io_q[i];
            2'b01:   src = pat[i];
            2'b10:   src = dbg0[i];
            default: src = dbg1[i];
         endcase
      end
      assign pad_out[i] = src & dir_q[i];
      assign pad_oe[i]  = dir_q[i];
   end
endmodule

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl
   import atr_gpio_pkg::*;
#(
   parameter int PIN_W     = 16,
   parameter bit SYNC_PADS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PIN_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [PIN_W-1:0]  rd_data,
   input  logic              tx_active,
   input  logic              rx_active,
   input  logic [PIN_W-1:0]  rx_pad_in,
   input  logic [PIN_W-1:0]  tx_pad_in,
   input  logic [PIN_W-1:0]  rx_dbg0,
   input  logic [PIN_W-1:0]  rx_dbg1,
   input  logic [PIN_W-1:0]  tx_dbg0,
   input  logic [PIN_W-1:0]  tx_dbg1,
   output logic [PIN_W-1:0]  rx_pad_out,
   output logic [PIN_W-1:0]  rx_pad_oe,
   output logic [PIN_W-1:0]  tx_pad_out,
   output logic [PIN_W-1:0]  tx_pad_oe
);
   localparam int IDX_W = $clog2(N_STATE);

   if (PIN_W < 1 || PIN_W > 32) begin : g_bad_width
      $error("atr_gpio_ctrl: PIN_W must be in 1..32");
   end
   if (ADDR_W != 4) begin : g_bad_addr
      $error("atr_gpio_ctrl: address map needs ADDR_W of 4");
   end

   logic [IDX_W-1:0] live_idx;
   assign live_idx = {tx_active, rx_active};

   logic [PIN_W-1:0] pad_in_a  [N_BANK];
   logic [PIN_W-1:0] pad_in_s  [N_BANK];
   logic [PIN_W-1:0] dbg0_a    [N_BANK];
   logic [PIN_W-1:0] dbg1_a    [N_BANK];
   logic [PIN_W-1:0] io_q_a    [N_BANK];
   logic [PIN_W-1:0] dir_q_a   [N_BANK];
   logic [PIN_W-1:0] sel_q_a   [N_BANK];
   logic [PIN_W-1:0] dbg_q_a   [N_BANK];
   logic [PIN_W-1:0] pat_live_a[N_BANK];
   logic [PIN_W-1:0] pat_rd_a  [N_BANK];
   logic [PIN_W-1:0] out_a     [N_BANK];
   logic [PIN_W-1:0] oe_a      [N_BANK];

   assign pad_in_a[0] = rx_pad_in;
   assign pad_in_a[1] = tx_pad_in;
   assign dbg0_a[0]   = rx_dbg0;
   assign dbg0_a[1]   = tx_dbg0;
   assign dbg1_a[0]   = rx_dbg1;
   assign dbg1_a[1]   = tx_dbg1;

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      logic bank_wr;
      logic pat_wr;
      assign bank_wr = wr_en && !wr_addr[3] && (wr_addr[2] == 1'(b));
      assign pat_wr  = wr_en &&  wr_addr[3] && (wr_addr[0] == 1'(b));

      atr_gpio_bank_regs #(.PIN_W(PIN_W)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bank_wr),
         .wr_reg  (bank_reg_e'(wr_addr[1:0])),
         .wr_data (wr_data),
         .io_q    (io_q_a[b]),
         .dir_q   (dir_q_a[b]),
         .sel_q   (sel_q_a[b]),
         .dbg_q   (dbg_q_a[b])
      );

      atr_gpio_pattern_tbl #(.PIN_W(PIN_W)) u_pat (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (pat_wr),
         .wr_idx   (wr_addr[2:1]),
         .wr_data  (wr_data),
         .live_idx (live_idx),
         .rd_idx   (rd_addr[2:1]),
         .pat_live (pat_live_a[b]),
         .pat_rd   (pat_rd_a[b])
      );

      atr_gpio_pinmux #(.PIN_W(PIN_W)) u_mux (
         .io_q    (io_q_a[b]),
         .dir_q   (dir_q_a[b]),
         .sel_q   (sel_q_a[b]),
         .dbg_q   (dbg_q_a[b]),
         .pat     (pat_live_a[b]),
         .dbg0    (dbg0_a[b]),
         .dbg1    (dbg1_a[b]),
         .pad_out (out_a[b]),
         .pad_oe  (oe_a[b])
      );

      if (SYNC_PADS) begin : g_sync
         logic [PIN_W-1:0] meta_q, sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               meta_q <= '0;
               sync_q <= '0;
            end else begin
               meta_q <= pad_in_a[b];
               sync_q <= meta_q;
            end
         end
         assign pad_in_s[b] = sync_q;
      end else begin : g_direct
         assign pad_in_s[b] = pad_in_a[b];
      end
   end

   assign rx_pad_out = out_a[0];
   assign rx_pad_oe  = oe_a[0];
   assign tx_pad_out = out_a[1];
   assign tx_pad_oe  = oe_a[1];

   always_comb begin
      if (rd_addr[3]) begin
         rd_data = pat_rd_a[rd_addr[0]];
      end else begin
         unique case (bank_reg_e'(rd_addr[1:0]))
            REG_IO:  rd_data = pad_in_s[rd_addr[2]];
            REG_DIR: rd_data = dir_q_a[rd_addr[2]];
            REG_SEL: rd_data = sel_q_a[rd_addr[2]];
            default: rd_data = dbg_q_a[rd_addr[2]];
         endcase
      end
   end
endmodule

// File: rtl/atr_gpio_ctrl_chk.sv
module atr_gpio_ctrl_chk #(
   parameter int PIN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [3:0]       wr_addr,
   input logic [PIN_W-1:0] wr_data,
   input logic [PIN_W-1:0] rx_pad_out,
   input logic [PIN_W-1:0] rx_pad_oe,
   input logic [PIN_W-1:0] tx_pad_out,
   input logic [PIN_W-1:0] tx_pad_oe,
   input logic [PIN_W-1:0] rx_dbg1,
   input logic [PIN_W-1:0] tx_dbg1,
   input logic [PIN_W-1:0] rx_dbg_r,
   input logic [PIN_W-1:0] rx_sel_r,
   input logic [PIN_W-1:0] tx_dbg_r,
   input logic [PIN_W-1:0] tx_sel_r
);
   // R1: leaving reset, no pin is enabled
   p_reset_inputs_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (rx_pad_oe == '0 && tx_pad_oe == '0));

   // R3: a direction write shows on the enables one cycle later
   p_rx_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'h1) |=> (rx_pad_oe == $past(wr_data)));
   p_tx_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'h5) |=> (tx_pad_oe == $past(wr_data)));

   // R8: input pins never carry a driven 1
   p_no_drive_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_pad_out & ~rx_pad_oe) == '0) && ((tx_pad_out & ~tx_pad_oe) == '0));

   // R7: debug pins with select set carry debug bus 1
   p_dbg1_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (((rx_pad_out ^ rx_dbg1) & rx_dbg_r & rx_sel_r & rx_pad_oe) == '0) &&
      (((tx_pad_out ^ tx_dbg1) & tx_dbg_r & tx_sel_r & tx_pad_oe) == '0));

   // R10: receive-bank register writes leave transmit enables alone
   p_bank_isolation_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr[3] && !wr_addr[2]) |=> $stable(tx_pad_oe));
endmodule

bind atr_gpio_ctrl atr_gpio_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .rx_pad_out (rx_pad_out),
   .rx_pad_oe  (rx_pad_oe),
   .tx_pad_out (tx_pad_out),
   .tx_pad_oe  (tx_pad_oe),
   .rx_dbg1    (rx_dbg1),
   .tx_dbg1    (tx_dbg1),
   .rx_dbg_r   (dbg_q_a[0]),
   .rx_sel_r   (sel_q_a[0]),
   .tx_dbg_r   (dbg_q_a[1]),
   .tx_sel_r   (sel_q_a[1])
);

// File: tb/atr_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module atr_gpio_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        tx_active = 1'b0, rx_active = 1'b0;
   logic [15:0] rx_pad_in = '0, tx_pad_in = '0;
   logic [15:0] rx_dbg0 = '0, rx_dbg1 = '0, tx_dbg0 = '0, tx_dbg1 = '0;
   logic [15:0] rx_pad_out, rx_pad_oe, tx_pad_out, tx_pad_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   atr_gpio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_active(tx_active), .rx_active(rx_active),
      .rx_pad_in(rx_pad_in), .tx_pad_in(tx_pad_in),
      .rx_dbg0(rx_dbg0), .rx_dbg1(rx_dbg1), .tx_dbg0(tx_dbg0), .tx_dbg1(tx_dbg1),
      .rx_pad_out(rx_pad_out), .rx_pad_oe(rx_pad_oe),
      .tx_pad_out(tx_pad_out), .tx_pad_oe(tx_pad_oe)
   );

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic set_flags(logic tx, logic rx);
      tx_active = tx; rx_active = rx;
      #1;
   endtask

   task automatic t_reset;
      check("R1", "rx oe", rx_pad_oe, 16'h0);
      check("R1", "tx oe", tx_pad_oe, 16'h0);
      check("R1", "rx out", rx_pad_out, 16'h0);
      rd_addr = 4'h1; #1; check("R1", "rx dir readback", rd_data, 16'h0);
      rd_addr = 4'hE; #1; check("R1", "pattern readback", rd_data, 16'h0);
   endtask

   task automatic t_software;
      wr(4'h0, 16'hA5C3);
      wr(4'h1, 16'hFFFF);
      check("R3", "rx oe all out", rx_pad_oe, 16'hFFFF);
      check("R4", "rx software value", rx_pad_out, 16'hA5C3);
   endtask

   task automatic t_direction;
      wr(4'h1, 16'h00FF);
      check("R3", "rx oe half", rx_pad_oe, 16'h00FF);
      check("R8", "rx inputs undriven", rx_pad_out, 16'h00C3);
      wr(4'h1, 16'hFFFF);
   endtask

   task automatic t_pattern;
      logic [15:0] pats [4];
      pats[0] = 16'h1111; pats[1] = 16'h2222; pats[2] = 16'h4444; pats[3] = 16'h8888;
      for (int s = 0; s < 4; s++) wr(4'h8 | 4'(s << 1), pats[s]);
      wr(4'h2, 16'hFFFF);
      for (int s = 0; s < 4; s++) begin
         set_flags(s[1], s[0]);
         check("R5", $sformatf("state %0d pattern", s), rx_pad_out, pats[s]);
      end
      set_flags(1'b0, 1'b1);
      check("R6", "flag change same cycle", rx_pad_out, 16'h2222);
      set_flags(1'b0, 1'b0);
      wr(4'h2, 16'hF0F0);
      check("R5", "mixed select idle", rx_pad_out, (16'hA5C3 & 16'h0F0F) | (16'h1111 & 16'hF0F0));
   endtask

   task automatic t_debug;
      rx_dbg0 = 16'h1357; rx_dbg1 = 16'h9BDF;
      wr(4'h3, 16'hFFFF);
      wr(4'h2, 16'h00FF);
      check("R7", "debug buses by select", rx_pad_out, 16'h13DF);
      wr(4'h3, 16'hFF00);
      check("R7", "debug half, pattern half", rx_pad_out, 16'h1311);
      wr(4'h1, 16'h0F0F);
      check("R8", "debug on inputs undriven", rx_pad_out, 16'h0301);
      wr(4'h1, 16'hFFFF);
   endtask

   task automatic t_tx_bank;
      logic [15:0] rx_before;
      rx_before = rx_pad_out;
      wr(4'h4, 16'h0F0F);
      wr(4'h5, 16'hFFFF);
      check("R4", "tx software value", tx_pad_out, 16'h0F0F);
      check("R10", "rx out unchanged by tx writes", rx_pad_out, rx_before);
      check("R10", "rx oe unchanged by tx writes", rx_pad_oe, 16'hFFFF);
      wr(4'hF, 16'hCAFE);
      wr(4'h6, 16'hFFFF);
      set_flags(1'b1, 1'b1);
      check("R5", "tx full duplex pattern", tx_pad_out, 16'hCAFE);
      check("R10", "rx pattern not hit by tx pattern write", rx_pad_out, 16'h1388);
      set_flags(1'b0, 1'b0);
      check("R5", "tx idle pattern empty", tx_pad_out, 16'h0000);
   endtask

   task automatic t_readback;
      rx_pad_in = 16'h3C3C; tx_pad_in = 16'hB00B;
      rd_addr = 4'h0; #1; check("R9", "rx io reads pads", rd_data, 16'h3C3C);
      rd_addr = 4'h4; #1; check("R9", "tx io reads pads", rd_data, 16'hB00B);
      rd_addr = 4'h2; #1; check("R9", "rx select", rd_data, 16'h00FF);
      rd_addr = 4'h3; #1; check("R9", "rx debug", rd_data, 16'hFF00);
      rd_addr = 4'hE; #1; check("R9", "rx full-duplex pattern", rd_data, 16'h8888);
      rd_addr = 4'hF; #1; check("R9", "tx full-duplex pattern", rd_data, 16'hCAFE);
      rd_addr = 4'hA; #1; check("R2", "rx receive-only pattern", rd_data, 16'h2222);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_software();
      t_direction();
      t_pattern();
      t_debug();
      t_tx_bank();
      t_readback();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule